// File: doc/BRIEF.md
# Dual-Clock Almost-Full Flag Generator

This block produces an active-low almost-full indication for a FIFO whose write side is clocked by `clk_a` and whose read side is clocked by `clk_b`. It keeps a write pointer in the write domain and a read pointer in the read domain. The read pointer crosses into the write domain as a Gray code through a two-flop synchronizer. The flag is a register in the write domain. It goes low once the number of long words held reaches `DEPTH - almost_ofs`, and it goes high again once reads bring the level below that point. The FIFO storage itself is not part of the block. The block only tracks the fill level and produces the flag.

The read port can be narrower than the 36-bit long word. A long word is then taken in two word-sized pieces or four byte-sized pieces, and only the read that takes the final piece frees a long word. A write is counted only when all four write-side controls are in their active state. The flag falls on the same `clk_a` edge as the write that reaches the threshold. Its rise follows a read only after the synchronizer latency, which gives a fixed and predictable deassertion edge when the clocks keep a safe skew.

Top module: `afull_flag_gen`

## Requirements
- R1: Once no read is in flight across the clock boundary, `af_n` is 0 when the long words held are at least `DEPTH - almost_ofs`, and 1 when they are fewer. `almost_ofs` is held static outside reset and lies in 0 to `DEPTH-1`.
- R2: A write is counted only on a `clk_a` rising edge where `en_a`=1, `cs_a_n`=0, `wr_sel_a`=1 and `mbox_a`=0. With any one of these four not in that state, the fill level and `af_n` do not change.
- R3: When a counted write brings the level up to `DEPTH - almost_ofs`, `af_n` is 0 right after that same `clk_a` edge.
- R4: `af_n` falls only on a `clk_a` edge where a counted write took place.
- R5: A read takes the last piece of a long word at a `clk_b` edge T, bringing the level below the threshold, and each `clk_a` edge follows a `clk_b` edge by a safe margin. Then `af_n` is still 0 after the first and second `clk_a` edges following T, and is 1 after the third. `af_n` rises only in the cycle after the synchronized read pointer has moved.
- R6: The read pointer crosses the clock boundary as a Gray code. Between consecutive `clk_b` edges, at most one bit of it changes.
- R7: `bus_width_b` sets the read granularity: 2'b00 reads a whole long word in one access, 2'b01 in two word pieces, and 2'b10 or 2'b11 in four byte pieces. Only the access that takes the last piece lowers the fill level. The piece count stays below the number of pieces. `bus_width_b` is changed only during reset.
- R8: Driving `rst_n` low clears both pointers and the piece count and forces `af_n` to 1 at once. The release of reset is synchronized separately into each clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a | input | 1 | Write-side enable, active high |
| cs_a_n | input | 1 | Write-side chip select, active low |
| wr_sel_a | input | 1 | Write-side direction, 1 = write |
| mbox_a | input | 1 | Write-side mailbox select, must be 0 for a FIFO write |
| rd_en_b | input | 1 | Read-side piece read strobe |
| bus_width_b | input | 2 | Read granularity: 00 long word, 01 word, 10/11 byte |
| almost_ofs | input | PW | Almost-full offset Y, threshold is DEPTH - Y |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
On every cycle, the assertions check four relations. The flag falls only on a counted write. It rises only after the synchronized read pointer has moved. The crossing pointer changes at most one bit per step. The piece counter stays inside the range set by the selected read width. The bench scenarios cover the rest. They check the actual threshold value for several offsets across a full fill and drain. They check the exact `clk_a` edge of deassertion in each read width, that non-final pieces leave the flag alone, that each disqualifying write-control combination is ignored, and that a mid-run reset returns the flag high.

// File: rtl/afg_pkg.sv
package afg_pkg;

  typedef enum logic [1:0] {
    BW_LONG  = 2'b00,
    BW_WORD  = 2'b01,
    BW_BYTE  = 2'b10,
    BW_BYTE2 = 2'b11
  } bus_width_e;

  // Index of the final piece of a long word for a given read width.
  function automatic logic [1:0] last_piece(input logic [1:0] bw);
    case (bus_width_e'(bw))
      BW_LONG: last_piece = 2'd0;
      BW_WORD: last_piece = 2'd1;
      default: last_piece = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/afg_reset_sync.sv
module afg_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/afg_rd_tracker.sv
module afg_rd_tracker #(
  parameter int PW = 9
) (
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    bus_width,
  output logic [PW-1:0] rd_gray,
  output logic [1:0]    piece_cnt
);

  import afg_pkg::*;

  logic [PW-1:0] bin_q, bin_d;
  logic [PW-1:0] gray_q, gray_d;
  logic [1:0]    piece_q, piece_d;
  logic          word_done;

  always_comb begin
    word_done = rd_en && (piece_q >= last_piece(bus_width));
    piece_d   = piece_q;
    if (rd_en) piece_d = word_done ? 2'd0 : piece_q + 2'd1;
    bin_d  = bin_q + PW'(word_done);
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      piece_q <= '0;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      piece_q <= piece_d;
    end
  end

  assign rd_gray   = gray_q;
  assign piece_cnt = piece_q;

endmodule

// File: rtl/afg_gray_sync.sv
module afg_gray_sync #(
  parameter int PW     = 9,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][PW-1:0] stage_q, stage_d;
  logic [PW-1:0]         gray_sync;

  always_comb begin
    stage_d = {stage_q[NS-2:0], gray_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign gray_sync = stage_q[NS-1];

  // Each binary bit is the parity of the Gray bits at and above it.
  for (genvar b = 0; b < PW; b++) begin : g_g2b
    assign bin_out[b] = ^gray_sync[PW-1:b];
  end

endmodule

// File: rtl/afg_wr_flag.sv
module afg_wr_flag #(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input  logic          clk_a,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [PW-1:0] rd_sync_bin,
  input  logic [PW-1:0] almost_ofs,
  output logic          af_n
);

  localparam logic [PW:0] DEPTH_W = (PW+1)'(DEPTH);

  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] fill_d;
  logic [PW:0]   thresh;
  logic          af_n_q, af_n_d;

  always_comb begin
    wr_d   = wr_q + PW'(wr_fire);
    fill_d = wr_d - rd_sync_bin;
    thresh = DEPTH_W - {1'b0, almost_ofs};
    af_n_d = ({1'b0, fill_d} < thresh);
  end

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      af_n_q <= 1'b1;
    end else begin
      wr_q   <= wr_d;
      af_n_q <= af_n_d;
    end
  end

  assign af_n = af_n_q;

endmodule

// File: rtl/afull_flag_gen.sv
module afull_flag_gen #(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(DEPTH) + 1
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          cs_a_n,
  input  logic          wr_sel_a,
  input  logic          mbox_a,
  input  logic          rd_en_b,
  input  logic [1:0]    bus_width_b,
  input  logic [PW-1:0] almost_ofs,
  output logic          af_n
);

  logic          rst_a_n;
  logic          rst_b_n;
  logic          wr_fire;
  logic [PW-1:0] rd_gray;
  logic [PW-1:0] rd_sync_bin;
  logic [1:0]    piece_cnt;

  afg_reset_sync u_rst_a (.clk(clk_a), .arst_n(rst_n), .rst_n_o(rst_a_n));
  afg_reset_sync u_rst_b (.clk(clk_b), .arst_n(rst_n), .rst_n_o(rst_b_n));

  assign wr_fire = en_a & ~cs_a_n & wr_sel_a & ~mbox_a;

  afg_rd_tracker #(.PW(PW)) u_rd (
    .clk_b     (clk_b),
    .rst_n     (rst_b_n),
    .rd_en     (rd_en_b),
    .bus_width (bus_width_b),
    .rd_gray   (rd_gray),
    .piece_cnt (piece_cnt)
  );

  afg_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_a),
    .rst_n   (rst_a_n),
    .gray_in (rd_gray),
    .bin_out (rd_sync_bin)
  );

  afg_wr_flag #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk_a       (clk_a),
    .rst_n       (rst_a_n),
    .wr_fire     (wr_fire),
    .rd_sync_bin (rd_sync_bin),
    .almost_ofs  (almost_ofs),
    .af_n        (af_n)
  );

endmodule

// File: rtl/afull_flag_gen_chk.sv
module afull_flag_gen_chk #(
  parameter int PW = 9
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_a_n,
  input logic          rst_b_n,
  input logic          en_a,
  input logic          cs_a_n,
  input logic          wr_sel_a,
  input logic          mbox_a,
  input logic          af_n,
  input logic [1:0]    bus_width_b,
  input logic [1:0]    piece_cnt,
  input logic [PW-1:0] rd_gray,
  input logic [PW-1:0] rd_sync_bin
);

  import afg_pkg::*;

  // R4: a falling flag needs a fully qualified write on that edge
  a_r4_fall_on_write: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $fell(af_n) |-> $past(en_a && !cs_a_n && wr_sel_a && !mbox_a));

  // R5: a rising flag needs the synchronized read pointer to have moved
  a_r5_rise_after_sync: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $rose(af_n) |-> ($past(rd_sync_bin) != $past(rd_sync_bin, 2)));

  // R6: the crossing pointer changes by at most one bit per step
  a_r6_gray_one_bit: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  // R7: the piece count stays inside the selected read width
  a_r7_piece_range: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    piece_cnt <= last_piece(bus_width_b));

endmodule

bind afull_flag_gen afull_flag_gen_chk #(.PW(PW)) u_chk (
  .clk_a       (clk_a),
  .clk_b       (clk_b),
  .rst_a_n     (rst_a_n),
  .rst_b_n     (rst_b_n),
  .en_a        (en_a),
  .cs_a_n      (cs_a_n),
  .wr_sel_a    (wr_sel_a),
  .mbox_a      (mbox_a),
  .af_n        (af_n),
  .bus_width_b (bus_width_b),
  .piece_cnt   (piece_cnt),
  .rd_gray     (rd_gray),
  .rd_sync_bin (rd_sync_bin)
);

// File: tb/afull_flag_gen_tb.sv
module afull_flag_gen_tb;

  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          clk_a = 1'b0;
  logic          clk_b = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_a = 1'b0, cs_a_n = 1'b1, wr_sel_a = 1'b0, mbox_a = 1'b0;
  logic          rd_en_b = 1'b0;
  logic [1:0]    bus_width_b = 2'b00;
  logic [PW-1:0] almost_ofs = '0;
  logic          af_n;

  int checks = 0;
  int fails  = 0;
  int level  = 0;
  int ofs    = 0;
  bit done   = 0;

  afull_flag_gen #(.DEPTH(DEPTH)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .en_a(en_a), .cs_a_n(cs_a_n), .wr_sel_a(wr_sel_a), .mbox_a(mbox_a),
    .rd_en_b(rd_en_b), .bus_width_b(bus_width_b),
    .almost_ofs(almost_ofs), .af_n(af_n)
  );

  // 50 MHz on both; clk_b rises 15 ns before each clk_a rise (5 ns after the previous one)
  always #10 clk_a = ~clk_a;
  initial begin
    #5;
    forever #10 clk_b = ~clk_b;
  end

  function automatic logic exp_flag(input int lvl, input int y);
    return (lvl >= DEPTH - y) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: af_n=%0b expected %0b (level=%0d ofs=%0d)", req, act, exp, level, ofs);
    end
  endtask

  task automatic do_reset(input int y, input logic [1:0] bw);
    @(negedge clk_a);
    rst_n = 1'b0;
    almost_ofs = PW'(y);
    bus_width_b = bw;
    ofs = y;
    level = 0;
    repeat (3) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_a);
  endtask

  task automatic drive_write(input logic en, input logic cs_n, input logic wsel, input logic mb);
    @(negedge clk_a);
    en_a = en; cs_a_n = cs_n; wr_sel_a = wsel; mbox_a = mb;
    @(negedge clk_a);
    en_a = 1'b0; cs_a_n = 1'b1; wr_sel_a = 1'b0; mbox_a = 1'b0;
  endtask

  task automatic read_piece();
    @(negedge clk_b);
    rd_en_b = 1'b1;
    @(negedge clk_b);
    rd_en_b = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_a);
  endtask

  // Exact deassertion edge: final piece read at clk_b edge T
  task automatic final_piece_timing(input string req);
    read_piece();
    level--;
    @(negedge clk_a);
    @(negedge clk_a);
    check(req, af_n, 1'b0);
    @(negedge clk_a);
    check(req, af_n, 1'b1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: af_n=%0b expected run to finish", af_n);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ylist[4] = '{0, 1, 5, 15};

    // R8: flag high out of reset
    do_reset(2, 2'b00);
    check("R8 reset value", af_n, 1'b1);

    // R1/R3: full fill and drain, long-word reads, several offsets
    foreach (ylist[i]) begin
      do_reset(ylist[i], 2'b00);
      for (int k = 0; k < DEPTH; k++) begin
        drive_write(1'b1, 1'b0, 1'b1, 1'b0);
        level++;
        check("R3 same-edge assert on write", af_n, exp_flag(level, ofs));
      end
      for (int k = 0; k < DEPTH; k++) begin
        read_piece();
        level--;
        settle();
        check("R1 steady-state level", af_n, exp_flag(level, ofs));
      end
    end

    // R5/R6: exact deassertion edge, long-word reads
    do_reset(2, 2'b00);
    for (int k = 0; k < DEPTH - 2; k++) begin
      drive_write(1'b1, 1'b0, 1'b1, 1'b0);
      level++;
    end
    check("R1 at threshold", af_n, 1'b0);
    final_piece_timing("R5 R6 long-word deassert edge");

    // R7: word width, first piece ignored, second frees a long word
    do_reset(2, 2'b01);
    for (int k = 0; k < DEPTH - 2; k++) begin
      drive_write(1'b1, 1'b0, 1'b1, 1'b0);
      level++;
    end
    read_piece();
    settle();
    check("R7 word piece 0 ignored", af_n, 1'b0);
    final_piece_timing("R7 R5 word final piece deassert");

    // R7: byte width (code 2'b10 and 2'b11), three pieces ignored
    for (int m = 2; m < 4; m++) begin
      do_reset(2, 2'(m));
      for (int k = 0; k < DEPTH - 2; k++) begin
        drive_write(1'b1, 1'b0, 1'b1, 1'b0);
        level++;
      end
      for (int p = 0; p < 3; p++) begin
        read_piece();
        settle();
        check("R7 byte non-final piece ignored", af_n, 1'b0);
      end
      final_piece_timing("R7 R5 byte final piece deassert");
    end

    // R2: each disqualified write leaves the level untouched
    do_reset(2, 2'b00);
    for (int k = 0; k < DEPTH - 3; k++) begin
      drive_write(1'b1, 1'b0, 1'b1, 1'b0);
      level++;
    end
    check("R2 one below threshold", af_n, 1'b1);
    drive_write(1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 enable low ignored", af_n, 1'b1);
    drive_write(1'b1, 1'b1, 1'b1, 1'b0);
    check("R2 chip select high ignored", af_n, 1'b1);
    drive_write(1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 read direction ignored", af_n, 1'b1);
    drive_write(1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 mailbox select ignored", af_n, 1'b1);
    drive_write(1'b1, 1'b0, 1'b1, 1'b0);
    level++;
    check("R2 R3 qualified write reaches threshold", af_n, 1'b0);

    // R8: reset while almost full
    @(negedge clk_a);
    rst_n = 1'b0;
    #1;
    check("R8 async reset forces flag high", af_n, 1'b1);
    do_reset(2, 2'b00);
    check("R8 flag high after release", af_n, 1'b1);
    drive_write(1'b1, 1'b0, 1'b1, 1'b0);
    level++;
    check("R8 pointers cleared", af_n, exp_flag(level, ofs));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule